// File: doc/BRIEF.md
# RC Link Failsafe and Arming Monitor

This block sits behind a radio-control frame decoder. Each time the decoder delivers a good frame, it pulses `frame_valid` with all sixteen 11-bit channel values on a flat bus. The block uses a free-running millisecond tick to track the age of the last frame and raises a failsafe disarm when the link goes silent. Before any frame has ever arrived, the link is treated as absent rather than lost, so no failsafe is raised.

Arming comes from one channel. A new crossing of that channel above a threshold starts a hold interval. The armed output rises only if the stick is still up when the interval ends. Pulling the stick down cancels the hold or disarms. A failsafe drops everything, and a fresh crossing is then needed. A second channel is scaled into a signed steering command with saturation.

Top module: `rc_link_guard`

## Requirements
- R1: Once a frame has been seen, `failsafe_disarm` is high whenever more than TIMEOUT_MS (default 300) ticks have passed since the last frame. With ticks on consecutive cycles, it rises after the 301st tick and falls in the cycle after the next `frame_valid`.
- R2: Until the first `frame_valid` after reset, `failsafe_disarm` stays low however many ticks arrive.
- R3: `rc_alive` is high from the cycle after a frame while at most TIMEOUT_MS ticks have passed since that frame. It is low before the first frame and whenever `failsafe_disarm` is high.
- R4: Channel k (k = 1..16) occupies `ch_data[11k-1:11k-11]`. An arm request is a frame whose channel 5 value is 1750 or more when channel 5 in the previous frame was below 1750; at reset the previous value counts as below. A frame at 1749 never requests arming.
- R5: After an arm request, `armed` rises in the cycle after the HOLD_MS-th tick (default 500) that follows the request. A frame with channel 5 below 1750 during the hold cancels it.
- R6: While armed, a frame with channel 5 below 1750 clears `armed` in the next cycle.
- R7: A failsafe clears `armed` and any hold in the following cycle. Arming again needs a new rising crossing. The frame that ends a failsafe cannot start a hold, even when its channel 5 is high.
- R8: The steering output starts at 0 after reset. On each frame it takes, in the next cycle, the value computed from channel 1 value r (channel 1 = `ch_data[10:0]`), and it holds that value between frames. For r at or above 992 the value is trunc((r-992)*400/819). For r below 992 it is -trunc((992-r)*400/820).
- R9: Channel 1 values of 172 or less give -400, and values of 1811 or more give +400. The steering output never leaves the range -400 to +400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| frame_valid | input | 1 | One-cycle pulse when a good frame is decoded |
| ch_data | input | 176 | Sixteen 11-bit channel values, channel 1 in the low bits |
| armed | output | 1 | Arming in effect |
| rc_alive | output | 1 | Link fresh after first frame |
| failsafe_disarm | output | 1 | Link timed out after having been seen |
| steer_cmd | output | 11 | Signed steering command |

## Verification
The two functions that can meet in one cycle are failsafe handling and arm-edge detection. The bench provokes this by letting the link expire with channel 5 low, then sending a recovery frame with channel 5 high. That frame must clear the failsafe without opening a hold, so `armed` stays low through a full hold interval of refreshed high frames. It rises only after a low frame followed by a high one. A second collision is tested by letting the link expire while the stick is held high and armed. The bench checks that `armed` drops one cycle after `failsafe_disarm` rises.

// File: rtl/rc_guard_pkg.sv
package rc_guard_pkg;
   typedef enum logic [1:0] {
      ARM_IDLE = 2'd0,
      ARM_HOLD = 2'd1,
      ARM_LIVE = 2'd2
   } arm_state_e;
endpackage

// File: rtl/rc_link_timer.sv
module rc_link_timer #(
   parameter int TIMEOUT_MS = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic frame_valid,
   output logic alive,
   output logic expired
);
   localparam int AGE_W = $clog2(TIMEOUT_MS + 2);
   localparam logic [AGE_W-1:0] LIMIT = AGE_W'(TIMEOUT_MS);

   logic             seen_q;
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         age_q  <= '0;
      end else if (frame_valid) begin
         seen_q <= 1'b1;
         age_q  <= '0;
      end else if (ms_tick && seen_q && (age_q <= LIMIT)) begin
         age_q  <= age_q + 1'b1;
      end
   end

   assign alive   = seen_q && (age_q <= LIMIT);
   assign expired = seen_q && (age_q >  LIMIT);
endmodule

// File: rtl/rc_arm_fsm.sv
module rc_arm_fsm
   import rc_guard_pkg::*;
#(
   parameter int CH_W    = 11,
   parameter int THRESH  = 1750,
   parameter int HOLD_MS = 500
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ms_tick,
   input  logic            frame_valid,
   input  logic [CH_W-1:0] arm_raw,
   input  logic            force_off,
   output logic            armed
);
   localparam int HOLD_W = $clog2(HOLD_MS + 1);
   localparam logic [HOLD_W-1:0] LAST = HOLD_W'(HOLD_MS - 1);
   localparam logic [CH_W-1:0]   THR  = CH_W'(THRESH);

   arm_state_e        state_q, state_d;
   logic [HOLD_W-1:0] cnt_q, cnt_d;
   logic              prev_high_q;
   logic              high, rise, drop;

   assign high = (arm_raw >= THR);
   assign rise = frame_valid && high && !prev_high_q;
   assign drop = frame_valid && !high;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (force_off) begin
         state_d = ARM_IDLE;
         cnt_d   = '0;
      end else begin
         case (state_q)
            ARM_IDLE: if (rise) begin
               state_d = ARM_HOLD;
               cnt_d   = '0;
            end
            ARM_HOLD: if (drop) begin
               state_d = ARM_IDLE;
            end else if (ms_tick) begin
               if (cnt_q == LAST) state_d = ARM_LIVE;
               else               cnt_d   = cnt_q + 1'b1;
            end
            ARM_LIVE: if (drop) state_d = ARM_IDLE;
            default:  state_d = ARM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ARM_IDLE;
         cnt_q       <= '0;
         prev_high_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (frame_valid) prev_high_q <= high;
      end
   end

   assign armed = (state_q == ARM_LIVE);
endmodule

// File: rtl/rc_steer_map.sv
module rc_steer_map #(
   parameter int CH_W      = 11,
   parameter int STEER_W   = 11,
   parameter int STEER_MAX = 400,
   parameter int CENTER    = 992,
   parameter int RAW_MIN   = 172,
   parameter int RAW_MAX   = 1811
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_valid,
   input  logic [CH_W-1:0]           raw,
   output logic signed [STEER_W-1:0] steer
);
   localparam int SPAN_HI = RAW_MAX - CENTER;
   localparam int SPAN_LO = CENTER - RAW_MIN;

   logic signed [STEER_W-1:0] steer_d;

   always_comb begin
      int r;
      int v;
      r = int'(raw);
      if (r <= RAW_MIN)      v = -STEER_MAX;
      else if (r >= RAW_MAX) v = STEER_MAX;
      else if (r >= CENTER)  v = ((r - CENTER) * STEER_MAX) / SPAN_HI;
      else                   v = -(((CENTER - r) * STEER_MAX) / SPAN_LO);
      if (v > STEER_MAX)  v = STEER_MAX;
      if (v < -STEER_MAX) v = -STEER_MAX;
      steer_d = STEER_W'(v);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           steer <= '0;
      else if (frame_valid) steer <= steer_d;
   end
endmodule

// File: rtl/rc_link_guard.sv
module rc_link_guard #(
   parameter int CH_COUNT   = 16,
   parameter int CH_W       = 11,
   parameter int ARM_CH     = 4,
   parameter int STEER_CH   = 0,
   parameter int ARM_THRESH = 1750,
   parameter int TIMEOUT_MS = 300,
   parameter int HOLD_MS    = 500,
   parameter int STEER_W    = 11,
   parameter int STEER_MAX  = 400,
   parameter int CENTER     = 992,
   parameter int RAW_MIN    = 172,
   parameter int RAW_MAX    = 1811
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ms_tick,
   input  logic                         frame_valid,
   input  logic [CH_COUNT*CH_W-1:0]     ch_data,
   output logic                         armed,
   output logic                         rc_alive,
   output logic                         failsafe_disarm,
   output logic signed [STEER_W-1:0]    steer_cmd
);
   localparam int RAW_TOP = (1 << CH_W) - 1;

   if (ARM_CH >= CH_COUNT || STEER_CH >= CH_COUNT) begin : g_bad_ch
      $error("channel index out of range");
   end
   if (ARM_THRESH > RAW_TOP) begin : g_bad_thr
      $error("threshold exceeds channel width");
   end
   if (!(RAW_MIN < CENTER && CENTER < RAW_MAX && RAW_MAX <= RAW_TOP)) begin : g_bad_span
      $error("steering span misordered");
   end
   if (STEER_MAX >= (1 << (STEER_W - 1))) begin : g_bad_steer
      $error("steering limit does not fit output");
   end
   if (HOLD_MS < 1 || TIMEOUT_MS < 1) begin : g_bad_time
      $error("intervals must be at least one tick");
   end

   logic [CH_W-1:0] ch [CH_COUNT];
   for (genvar g = 0; g < CH_COUNT; g++) begin : g_unpack
      assign ch[g] = ch_data[g*CH_W +: CH_W];
   end

   logic link_expired;

   rc_link_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_valid(frame_valid),
      .alive(rc_alive), .expired(link_expired)
   );

   rc_arm_fsm #(.CH_W(CH_W), .THRESH(ARM_THRESH), .HOLD_MS(HOLD_MS)) u_arm (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_valid(frame_valid),
      .arm_raw(ch[ARM_CH]), .force_off(link_expired), .armed(armed)
   );

   rc_steer_map #(
      .CH_W(CH_W), .STEER_W(STEER_W), .STEER_MAX(STEER_MAX),
      .CENTER(CENTER), .RAW_MIN(RAW_MIN), .RAW_MAX(RAW_MAX)
   ) u_steer (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
      .raw(ch[STEER_CH]), .steer(steer_cmd)
   );

   assign failsafe_disarm = link_expired;
endmodule

// File: rtl/rc_link_guard_chk.sv
module rc_link_guard_chk #(
   parameter int CH_COUNT   = 16,
   parameter int CH_W       = 11,
   parameter int ARM_CH     = 4,
   parameter int ARM_THRESH = 1750,
   parameter int STEER_W    = 11,
   parameter int STEER_MAX  = 400
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ms_tick,
   input logic                      frame_valid,
   input logic [CH_COUNT*CH_W-1:0]  ch_data,
   input logic                      armed,
   input logic                      rc_alive,
   input logic                      failsafe_disarm,
   input logic signed [STEER_W-1:0] steer_cmd
);
   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)           seen_q <= 1'b0;
      else if (frame_valid) seen_q <= 1'b1;
   end

   logic arm_low;
   assign arm_low = ch_data[ARM_CH*CH_W +: CH_W] < CH_W'(ARM_THRESH);

   a_r2_quiet_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !failsafe_disarm);

   a_r3_alive_excludes_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
      !(rc_alive && failsafe_disarm));

   a_r1_frame_revives: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> (rc_alive && !failsafe_disarm));

   a_r6_low_frame_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && arm_low) |=> !armed);

   a_r7_failsafe_drops_arm: assert property (@(posedge clk) disable iff (!rst_n)
      failsafe_disarm |=> !armed);

   a_r8_steer_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> $stable(steer_cmd));

   a_r9_steer_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (steer_cmd <= STEER_W'(STEER_MAX)) && (steer_cmd >= -STEER_W'(STEER_MAX)));
endmodule

bind rc_link_guard rc_link_guard_chk #(
   .CH_COUNT(CH_COUNT), .CH_W(CH_W), .ARM_CH(ARM_CH), .ARM_THRESH(ARM_THRESH),
   .STEER_W(STEER_W), .STEER_MAX(STEER_MAX)
) u_chk (.*);

// File: tb/rc_link_guard_test.sv
`timescale 1ns/1ps
module rc_link_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic        frame_valid = 1'b0;
   logic [175:0] ch_data = '0;
   logic        armed, rc_alive, failsafe_disarm;
   logic signed [10:0] steer_cmd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rc_link_guard uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_valid(frame_valid),
      .ch_data(ch_data), .armed(armed), .rc_alive(rc_alive),
      .failsafe_disarm(failsafe_disarm), .steer_cmd(steer_cmd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_frame(input int s1, input int a5);
      @(negedge clk);
      for (int k = 0; k < 16; k++) ch_data[k*11 +: 11] = 11'd992;
      ch_data[10:0]  = 11'(s1);
      ch_data[54:44] = 11'(a5);
      frame_valid = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ms_tick = 1'b1;
         @(negedge clk); ms_tick = 1'b0;
      end
   endtask

   // ticks with a refresh frame every 100 ticks to keep the link up
   task automatic live_ticks(input int n, input int a5);
      for (int i = 0; i < n; i++) begin
         if (i % 100 == 99) send_frame(992, a5);
         tick(1);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check(armed == 0, "R6 reset armed", armed, 0);
      check(rc_alive == 0, "R3 reset alive", rc_alive, 0);
      check(failsafe_disarm == 0, "R2 reset failsafe", failsafe_disarm, 0);
      check(steer_cmd == 0, "R8 reset steer", steer_cmd, 0);
   endtask

   task automatic t_pre_frame();
      do_reset();
      tick(400);
      check(failsafe_disarm == 0, "R2 no failsafe before first frame", failsafe_disarm, 0);
      check(rc_alive == 0, "R3 not alive before first frame", rc_alive, 0);
   endtask

   task automatic t_timeout();
      do_reset();
      send_frame(992, 1000);
      check(rc_alive == 1, "R3 alive after frame", rc_alive, 1);
      tick(300);
      check(rc_alive == 1, "R3 alive at 300 ticks", rc_alive, 1);
      check(failsafe_disarm == 0, "R1 no failsafe at 300 ticks", failsafe_disarm, 0);
      tick(1);
      check(failsafe_disarm == 1, "R1 failsafe at 301 ticks", failsafe_disarm, 1);
      check(rc_alive == 0, "R3 not alive in failsafe", rc_alive, 0);
      send_frame(992, 1000);
      check(failsafe_disarm == 0, "R1 frame clears failsafe", failsafe_disarm, 0);
      check(rc_alive == 1, "R3 alive again", rc_alive, 1);
   endtask

   task automatic t_threshold_hold();
      do_reset();
      send_frame(992, 1749);
      live_ticks(600, 1749);
      check(armed == 0, "R4 1749 never arms", armed, 0);
      send_frame(992, 1750);
      live_ticks(499, 1750);
      check(armed == 0, "R5 not armed before hold ends", armed, 0);
      tick(1);
      @(negedge clk);
      check(armed == 1, "R5 armed after hold", armed, 1);
   endtask

   task automatic t_cancel_and_disarm();
      do_reset();
      send_frame(992, 1000);
      send_frame(992, 2000);
      live_ticks(200, 2000);
      send_frame(992, 1500);
      live_ticks(400, 1500);
      check(armed == 0, "R5 drop cancels hold", armed, 0);
      send_frame(992, 1900);
      live_ticks(500, 1900);
      @(negedge clk);
      check(armed == 1, "R4 new crossing arms", armed, 1);
      send_frame(992, 1749);
      check(armed == 0, "R6 low frame disarms", armed, 0);
   endtask

   task automatic t_failsafe();
      do_reset();
      send_frame(992, 1000);
      send_frame(992, 1800);
      live_ticks(500, 1800);
      @(negedge clk);
      check(armed == 1, "R7 setup armed", armed, 1);
      tick(301);
      check(failsafe_disarm == 1, "R7 failsafe raised", failsafe_disarm, 1);
      @(negedge clk);
      check(armed == 0, "R7 failsafe drops arm", armed, 0);
      send_frame(992, 1800);
      live_ticks(600, 1800);
      check(armed == 0, "R7 stick still high does not rearm", armed, 0);
      // collision: recovery frame with high arm channel
      send_frame(992, 1000);
      tick(301);
      send_frame(992, 1800);
      check(failsafe_disarm == 0, "R7 recovery clears failsafe", failsafe_disarm, 0);
      live_ticks(600, 1800);
      check(armed == 0, "R7 recovery frame cannot start hold", armed, 0);
      send_frame(992, 1000);
      send_frame(992, 1800);
      live_ticks(500, 1800);
      @(negedge clk);
      check(armed == 1, "R7 fresh crossing rearms", armed, 1);
   endtask

   task automatic steer_case(input int raw, input int exp, input string req);
      send_frame(raw, 1000);
      check(steer_cmd == 11'(exp), req, steer_cmd, exp);
   endtask

   task automatic t_steer();
      do_reset();
      steer_case(992, 0, "R8 centre");
      steer_case(1500, 248, "R8 upper half");
      steer_case(500, -240, "R8 lower half");
      steer_case(1000, 3, "R8 truncation");
      steer_case(1811, 400, "R9 top of span");
      steer_case(172, -400, "R9 bottom of span");
      steer_case(2047, 400, "R9 saturate high");
      steer_case(0, -400, "R9 saturate low");
      steer_case(1200, 101, "R8 mid value");
      tick(50);
      check(steer_cmd == 11'sd101, "R8 holds between frames", steer_cmd, 101);
   endtask

   initial begin
      #750000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_pre_frame();
      t_timeout();
      t_threshold_hold();
      t_cancel_and_disarm();
      t_failsafe();
      t_steer();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule